// File: doc/BRIEF.md
# Programmable Parallel Port with Handshake

This block is the register-mapped I/O section of a peripheral: an 8-bit bus interface that reaches a write-only configuration register, a readable status register, two 8-bit general-purpose ports (A and B), a 6-bit port C and two timer holding registers. Each of ports A and B can be set as an input or an output. Port C is either a plain 6-bit input or output port, or it gives up three of its pins per port to handshake lines: an interrupt request, a buffer-full flag and a strobe input.

A processor writes a configuration byte to address 0, then moves data through the port addresses. In a handshake configuration, a peripheral strobes data into an input port, or takes data from an output port, and the interrupt and buffer-full pins tell both sides when the buffer may be touched. The bus is sampled on the rising edge of `clk`. A read returns its data combinationally in the same cycle, and its side effects (flag clears) take hold at that edge. The timer registers only store and return what is written; the counting itself lies outside this block.

Top module: `pio_section`

## Requirements
- R1: After reset, every output-enable is 0, the port output latches are 0, and a status read returns 0 when `tc_flag` is 0.
- R2: An access takes effect only while `io_m` is 1 and `ce` is at its active level (high by default, set by `CE_ACTIVE_HIGH`). Only `addr[2:0]` are decoded, so the upper address bits are ignored. A write outside an access changes nothing, and `rdata` is 0 whenever no read access is under way.
- R3: A write to address 0 loads the configuration. A read of address 0 never returns it; it returns status instead: bit0 A interrupt, bit1 A buffer-full, bit2 A interrupt enable, bit3 B interrupt, bit4 B buffer-full, bit5 B interrupt enable, bit6 `tc_flag`, bit7 zero.
- R4: Configuration bit0 (port A) and bit1 (port B) set to 1 make that port an output: all its enables go high and its pins carry the latch written at address 1 (A) or 2 (B). A read of an output port returns that latch.
- R5: A port that is an input and not in handshake use returns its pins directly when read.
- R6: Configuration bits 3:2 select the use of port C: 00 all input, 11 all output (driving the latch written at address 3), 01 handshake for A with pins 5:3 as outputs, 10 handshake for both A and B. A read of port C returns the driven value for each output pin and the pin level for each other pin.
- R7: In handshake use, pins 0, 1 and 2 carry A's interrupt (out), buffer-full (out) and active-low strobe (in), and pins 3, 4 and 5 carry the same three lines for B.
- R8: A configuration write that places a port in handshake use sets that port's buffer-full to 0, and sets its interrupt to 1 if the port becomes an output and to 0 if it becomes an input.
- R9: Handshake input: a falling strobe captures the pins into the input latch and sets buffer-full. The rising strobe sets the interrupt only if the port's enable (bit4 for A, bit5 for B) is 1. A port read returns the captured byte and clears both flags.
- R10: Handshake output: a processor write to the port sets buffer-full and clears the interrupt. A rising strobe clears buffer-full and, if enabled, sets the interrupt.
- R11: When flag events coincide, an input port's strobe events win over the clear caused by a read, and an output port's processor write wins over the strobe release.
- R12: Addresses 4 and 5 store a byte each and return it when read. Addresses 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Chip enable, polarity set by parameter |
| io_m | input | 1 | 1 selects the register space |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | ADDR_W | Register address; low three bits decoded |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, 0 when no read access |
| tc_flag | input | 1 | Timer terminal-count flag shown in status |
| pa_in | input | DATA_W | Port A pin levels |
| pa_out | output | DATA_W | Port A drive value |
| pa_oe | output | DATA_W | Port A output enables |
| pb_in | input | DATA_W | Port B pin levels |
| pb_out | output | DATA_W | Port B drive value |
| pb_oe | output | DATA_W | Port B output enables |
| pc_in | input | PC_W | Port C pin levels |
| pc_out | output | PC_W | Port C drive value |
| pc_oe | output | PC_W | Port C output enables |

## Verification
Two flag events can land on the same clock edge: a strobe release from the peripheral, and a processor access to the same port (a read on an input port, a write on an output port). The bench provokes this by raising the strobe pin in the very cycle that its bus task issues the access. It then reads status and expects the strobe to have set the interrupt on the input port, while on the output port the write keeps buffer-full set and the interrupt cleared. A falling strobe that coincides with later pin changes is also covered: the byte read back must be the one present at the fall.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;

   // register selected by the low three address bits
   typedef enum logic [2:0] {
      RS_CTRL = 3'd0,
      RS_PA   = 3'd1,
      RS_PB   = 3'd2,
      RS_PC   = 3'd3,
      RS_TLO  = 3'd4,
      RS_THI  = 3'd5,
      RS_GAP6 = 3'd6,
      RS_GAP7 = 3'd7
   } reg_sel_e;

   // use of port C, from configuration bits 3:2
   typedef enum logic [1:0] {
      PCM_IN    = 2'b00,
      PCM_HS_A  = 2'b01,
      PCM_HS_AB = 2'b10,
      PCM_OUT   = 2'b11
   } pc_mode_e;

   localparam int CFG_W      = 6;
   localparam int CB_A_OUT   = 0;
   localparam int CB_PCM_LO  = 2;
   localparam int CB_IE_A    = 4;

   // is port idx (0 = A, 1 = B) in handshake use under mode m
   function automatic logic port_hs(pc_mode_e m, int idx);
      if (idx == 0) return (m == PCM_HS_A) || (m == PCM_HS_AB);
      else          return (m == PCM_HS_AB);
   endfunction

endpackage

// File: rtl/pio_decode.sv
`timescale 1ns/1ps
module pio_decode
   import pio_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter bit CE_ACTIVE_HIGH = 1'b1
) (
   input  logic              ce,
   input  logic              io_m,
   input  logic              rd,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic              rd_hit,
   output logic              wr_hit
);

   logic ce_on;

   generate
      if (CE_ACTIVE_HIGH) begin : g_ce_high
         assign ce_on = ce;
      end else begin : g_ce_low
         assign ce_on = ~ce;
      end

      if (ADDR_W > 3) begin : g_hi_bits
         logic unused_addr_hi;
         assign unused_addr_hi = ^addr[ADDR_W-1:3];
      end
   endgenerate

   assign sel    = reg_sel_e'(addr[2:0]);
   assign rd_hit = ce_on & io_m & rd;
   assign wr_hit = ce_on & io_m & wr;

endmodule

// File: rtl/pio_hs_port.sv
`timescale 1ns/1ps
module pio_hs_port #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         is_out,
   input  logic         hs_on,
   input  logic         ie,
   input  logic         init,
   input  logic         init_intr,
   input  logic         cpu_wr,
   input  logic         cpu_rd,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin,
   input  logic         stb_n,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] rd_val,
   output logic         intr,
   output logic         bf
);

   logic         stb_q;
   logic         stb_fall;
   logic         stb_rise;
   logic [W-1:0] out_q;
   logic [W-1:0] in_q;
   logic         intr_q, bf_q;
   logic         intr_n, bf_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b1;
      else        stb_q <= stb_n;
   end

   assign stb_fall = hs_on &  stb_q & ~stb_n;
   assign stb_rise = hs_on & ~stb_q &  stb_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q <= '0;
      else if (cpu_wr) out_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   in_q <= '0;
      else if (stb_fall && !is_out) in_q <= pin;
   end

   always_comb begin
      intr_n = intr_q;
      bf_n   = bf_q;
      if (init) begin
         bf_n   = 1'b0;
         intr_n = init_intr;
      end else if (!hs_on) begin
         bf_n   = 1'b0;
         intr_n = 1'b0;
      end else if (!is_out) begin
         // read clears first; strobe events then override
         if (cpu_rd) begin
            bf_n   = 1'b0;
            intr_n = 1'b0;
         end
         if (stb_fall)       bf_n   = 1'b1;
         if (stb_rise && ie) intr_n = 1'b1;
      end else begin
         // strobe release first; processor write then overrides
         if (stb_rise) begin
            bf_n = 1'b0;
            if (ie) intr_n = 1'b1;
         end
         if (cpu_wr) begin
            bf_n   = 1'b1;
            intr_n = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intr_q <= 1'b0;
         bf_q   <= 1'b0;
      end else begin
         intr_q <= intr_n;
         bf_q   <= bf_n;
      end
   end

   assign pin_out = out_q;
   assign pin_oe  = {W{is_out}};
   assign rd_val  = is_out ? out_q : (hs_on ? in_q : pin);
   assign intr    = intr_q;
   assign bf      = bf_q;

endmodule

// File: rtl/pio_portc.sv
`timescale 1ns/1ps
module pio_portc
   import pio_pkg::*;
#(
   parameter int PC_W  = 6,
   parameter int NPORT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PC_W-1:0]  wdata,
   input  pc_mode_e         mode,
   input  logic [NPORT-1:0] intr,
   input  logic [NPORT-1:0] bf,
   input  logic [PC_W-1:0]  pin,
   output logic [PC_W-1:0]  pc_out,
   output logic [PC_W-1:0]  pc_oe,
   output logic [PC_W-1:0]  rd_val,
   output logic [NPORT-1:0] stb_n
);

   localparam int GRP = PC_W / NPORT;

   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pc_q <= '0;
      else if (wr_en) pc_q <= wdata;
   end

   generate
      for (genvar g = 0; g < NPORT; g++) begin : g_grp
         localparam int B0 = g * GRP;
         logic           hs;
         logic           plain_out;
         logic [GRP-1:0] grp_out;
         logic [GRP-1:0] grp_oe;

         assign hs        = port_hs(mode, g);
         assign plain_out = (mode == PCM_OUT) || ((mode == PCM_HS_A) && (g != 0));

         always_comb begin
            if (hs) begin
               grp_out    = '0;
               grp_out[0] = intr[g];
               grp_out[1] = bf[g];
               grp_oe     = '0;
               grp_oe[0]  = 1'b1;
               grp_oe[1]  = 1'b1;
            end else begin
               grp_out = pc_q[B0 +: GRP];
               grp_oe  = {GRP{plain_out}};
            end
         end

         assign pc_out[B0 +: GRP] = grp_out;
         assign pc_oe[B0 +: GRP]  = grp_oe;
         assign stb_n[g]          = pin[B0 + 2];
      end
   endgenerate

   assign rd_val = (pc_oe & pc_out) | (~pc_oe & pin);

endmodule

// File: rtl/pio_section.sv
`timescale 1ns/1ps
module pio_section
   import pio_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 8,
   parameter int PC_W           = 6,
   parameter bit CE_ACTIVE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              io_m,
   input  logic              rd,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              tc_flag,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe,
   input  logic [PC_W-1:0]   pc_in,
   output logic [PC_W-1:0]   pc_out,
   output logic [PC_W-1:0]   pc_oe
);

   localparam int NPORT = 2;
   localparam int HS_W  = 3;

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("pio_section: DATA_W must be at least 8");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("pio_section: ADDR_W must be at least 3");
      end
      if (PC_W != NPORT * HS_W) begin : g_bad_pc
         $error("pio_section: PC_W must equal three lines per handshake port");
      end
   endgenerate

   reg_sel_e   sel;
   logic       rd_hit, wr_hit;
   logic       cfg_wr;
   logic [CFG_W-1:0] cmd_q;
   pc_mode_e   pcm, pcm_new;

   logic [DATA_W-1:0] tmr_lo, tmr_hi;
   logic [DATA_W-1:0] status;

   logic [NPORT-1:0][DATA_W-1:0] pin_a, out_a, oe_a, rdv_a;
   logic [NPORT-1:0] intr_v, bf_v, stb_v;
   logic [PC_W-1:0]  pc_rd;

   pio_decode #(
      .ADDR_W         (ADDR_W),
      .CE_ACTIVE_HIGH (CE_ACTIVE_HIGH)
   ) u_dec (
      .ce     (ce),
      .io_m   (io_m),
      .rd     (rd),
      .wr     (wr),
      .addr   (addr),
      .sel    (sel),
      .rd_hit (rd_hit),
      .wr_hit (wr_hit)
   );

   assign cfg_wr  = wr_hit && (sel == RS_CTRL);
   assign pcm     = pc_mode_e'(cmd_q[CB_PCM_LO +: 2]);
   assign pcm_new = pc_mode_e'(wdata[CB_PCM_LO +: 2]);

   // configuration: write-only, never on the read path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmd_q <= '0;
      else if (cfg_wr) cmd_q <= wdata[CFG_W-1:0];
   end

   // timer holding registers (counting lies outside this block)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_lo <= '0;
         tmr_hi <= '0;
      end else if (wr_hit) begin
         if (sel == RS_TLO) tmr_lo <= wdata;
         if (sel == RS_THI) tmr_hi <= wdata;
      end
   end

   assign pin_a[0] = pa_in;
   assign pin_a[1] = pb_in;

   generate
      for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
         logic sel_me;
         assign sel_me = (int'(sel) == int'(RS_PA) + gp);

         pio_hs_port #(
            .W (DATA_W)
         ) u_hs (
            .clk       (clk),
            .rst_n     (rst_n),
            .is_out    (cmd_q[CB_A_OUT + gp]),
            .hs_on     (port_hs(pcm, gp)),
            .ie        (cmd_q[CB_IE_A + gp]),
            .init      (cfg_wr && port_hs(pcm_new, gp)),
            .init_intr (wdata[CB_A_OUT + gp]),
            .cpu_wr    (wr_hit && sel_me),
            .cpu_rd    (rd_hit && sel_me),
            .wdata     (wdata),
            .pin       (pin_a[gp]),
            .stb_n     (stb_v[gp]),
            .pin_out   (out_a[gp]),
            .pin_oe    (oe_a[gp]),
            .rd_val    (rdv_a[gp]),
            .intr      (intr_v[gp]),
            .bf        (bf_v[gp])
         );
      end
   endgenerate

   assign pa_out = out_a[0];
   assign pa_oe  = oe_a[0];
   assign pb_out = out_a[1];
   assign pb_oe  = oe_a[1];

   pio_portc #(
      .PC_W  (PC_W),
      .NPORT (NPORT)
   ) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_hit && (sel == RS_PC)),
      .wdata  (wdata[PC_W-1:0]),
      .mode   (pcm),
      .intr   (intr_v),
      .bf     (bf_v),
      .pin    (pc_in),
      .pc_out (pc_out),
      .pc_oe  (pc_oe),
      .rd_val (pc_rd),
      .stb_n  (stb_v)
   );

   always_comb begin
      status    = '0;
      status[0] = intr_v[0];
      status[1] = bf_v[0];
      status[2] = cmd_q[CB_IE_A];
      status[3] = intr_v[1];
      status[4] = bf_v[1];
      status[5] = cmd_q[CB_IE_A + 1];
      status[6] = tc_flag;
   end

   always_comb begin
      rdata = '0;
      if (rd_hit) begin
         case (sel)
            RS_CTRL: rdata = status;
            RS_PA:   rdata = rdv_a[0];
            RS_PB:   rdata = rdv_a[1];
            RS_PC:   rdata = DATA_W'(pc_rd);
            RS_TLO:  rdata = tmr_lo;
            RS_THI:  rdata = tmr_hi;
            default: rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/pio_section_chk.sv
`timescale 1ns/1ps
module pio_section_chk #(
   parameter int DATA_W         = 8,
   parameter bit CE_ACTIVE_HIGH = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce,
   input logic              io_m,
   input logic              rd,
   input logic              wr,
   input logic [2:0]        addr_lo,
   input logic              wdata0,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] pa_oe,
   input logic              stb_a_n,
   input logic [1:0]        flags_a,
   input logic              a_out,
   input logic [1:0]        pc_sel,
   input logic              ie_a
);

   logic acc, hs_a, hs_a_in, hs_a_out, cfg_wr;

   assign acc      = (CE_ACTIVE_HIGH ? ce : ~ce) & io_m;
   assign hs_a     = (pc_sel == 2'b01) || (pc_sel == 2'b10);
   assign hs_a_in  = hs_a && !a_out;
   assign hs_a_out = hs_a && a_out;
   assign cfg_wr   = acc && wr && (addr_lo == 3'd0);

   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && rd) |-> (rdata == '0)); // R2

   AST_CFG_NOT_READABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && rd && addr_lo == 3'd0) |-> (rdata[DATA_W-1] == 1'b0)); // R3

   AST_DIR_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (pa_oe == {DATA_W{$past(wdata0)}})); // R4

   AST_STB_FALL_SETS_BF: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_a_in && $fell(stb_a_n) && !cfg_wr) |=> flags_a[1]); // R9

   AST_NO_INTR_WITHOUT_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_a_in && !ie_a && $past(hs_a_in && !ie_a)) |-> !$rose(flags_a[0])); // R9

   AST_WR_FILLS_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_a_out && acc && wr && addr_lo == 3'd1) |=> (flags_a[1] && !flags_a[0])); // R10

endmodule

bind pio_section pio_section_chk #(
   .DATA_W         (DATA_W),
   .CE_ACTIVE_HIGH (CE_ACTIVE_HIGH)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ce      (ce),
   .io_m    (io_m),
   .rd      (rd),
   .wr      (wr),
   .addr_lo (addr[2:0]),
   .wdata0  (wdata[0]),
   .rdata   (rdata),
   .pa_oe   (pa_oe),
   .stb_a_n (pc_in[2]),
   .flags_a (pc_out[1:0]),
   .a_out   (cmd_q[0]),
   .pc_sel  (cmd_q[3:2]),
   .ie_a    (cmd_q[4])
);

// File: tb/tb_pio_section.sv
`timescale 1ns/1ps
module tb_pio_section;

   logic       clk = 1'b0;
   logic       rst_n, ce, io_m, rd, wr, tc_flag;
   logic [7:0] addr, wdata, rdata;
   logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;
   logic [5:0] pc_in, pc_out, pc_oe;

   always #2.5 clk = ~clk;

   pio_section dut (
      .clk (clk), .rst_n (rst_n), .ce (ce), .io_m (io_m), .rd (rd), .wr (wr),
      .addr (addr), .wdata (wdata), .rdata (rdata), .tc_flag (tc_flag),
      .pa_in (pa_in), .pa_out (pa_out), .pa_oe (pa_oe),
      .pb_in (pb_in), .pb_out (pb_out), .pb_oe (pb_oe),
      .pc_in (pc_in), .pc_out (pc_out), .pc_oe (pc_oe)
   );

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   // monitor: pops one expected item for every read access seen mid-cycle
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rd === 1'b1 && io_m === 1'b1 && ce === 1'b1) begin
            if (exp_q.size() == 0) begin
               chk("scoreboard: read with no expectation", 32'(rdata), 32'hFFFF_FFFF);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(e.tag, 32'(rdata), 32'(e.exp));
            end
         end
      end
   end

   task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, input logic [5:0] pcs = 6'h00);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1; io_m = 1'b1; ce = 1'b1;
      pc_in = pc_in | pcs;
      @(negedge clk);
      wr = 1'b0; io_m = 1'b0; ce = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, input logic [7:0] exp, input string tag,
                         input logic [5:0] pcs = 6'h00);
      exp_t e;
      @(negedge clk);
      e.exp = exp; e.tag = tag;
      exp_q.push_back(e);
      addr = a; rd = 1'b1; io_m = 1'b1; ce = 1'b1;
      pc_in = pc_in | pcs;
      @(negedge clk);
      rd = 1'b0; io_m = 1'b0; ce = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ce = 1'b0; io_m = 1'b0; rd = 1'b0; wr = 1'b0;
      addr = '0; wdata = '0; tc_flag = 1'b0;
      pa_in = '0; pb_in = '0; pc_in = 6'h24;
      idle(3);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 pa_oe", 32'(pa_oe), 32'h00);
      chk("R1 pb_oe", 32'(pb_oe), 32'h00);
      chk("R1 pc_oe", 32'(pc_oe), 32'h00);
      chk("R1 pa_out", 32'(pa_out), 32'h00);
      bus_rd(8'h00, 8'h00, "R1 status after reset");

      // R2 qualified access only
      @(negedge clk);
      addr = 8'h00; wdata = 8'h03; wr = 1'b1; io_m = 1'b0; ce = 1'b1;
      @(negedge clk);
      io_m = 1'b1; ce = 1'b0;
      @(negedge clk);
      wr = 1'b0; io_m = 1'b0;
      #1;
      chk("R2 unqualified write ignored", 32'(pa_oe), 32'h00);
      @(negedge clk);
      addr = 8'h01; rd = 1'b1; io_m = 1'b0; ce = 1'b1;
      #1;
      chk("R2 rdata zero without io_m", 32'(rdata), 32'h00);
      @(negedge clk);
      rd = 1'b0; ce = 1'b0;

      // R2/R4 upper address bits ignored, ports A and B as outputs
      bus_wr(8'hF8, 8'h03);
      #1;
      chk("R4 pa_oe output", 32'(pa_oe), 32'hFF);
      chk("R4 pb_oe output", 32'(pb_oe), 32'hFF);
      bus_rd(8'hE0, 8'h00, "R3 cfg not returned on read");
      bus_wr(8'h01, 8'hA5);
      bus_wr(8'h42, 8'h3C);
      #1;
      chk("R4 pa_out", 32'(pa_out), 32'hA5);
      chk("R4 pb_out", 32'(pb_out), 32'h3C);
      bus_rd(8'h21, 8'hA5, "R4 output latch read A");
      bus_rd(8'h02, 8'h3C, "R4 output latch read B");

      // R5 basic input
      bus_wr(8'h00, 8'h00);
      pa_in = 8'h5A; pb_in = 8'h77;
      bus_rd(8'h01, 8'h5A, "R5 basic input A");
      pa_in = 8'hC3;
      bus_rd(8'h01, 8'hC3, "R5 basic input A second");
      bus_rd(8'h02, 8'h77, "R5 basic input B");

      // R6 port C plain modes
      bus_wr(8'h00, 8'h0C);
      bus_wr(8'h03, 8'h2A);
      #1;
      chk("R6 pc_oe all out", 32'(pc_oe), 32'h3F);
      chk("R6 pc_out latch", 32'(pc_out), 32'h2A);
      bus_rd(8'h03, 8'h2A, "R6 pc read driven");
      bus_wr(8'h00, 8'h00);
      pc_in = 6'h15;
      #1;
      chk("R6 pc_oe all in", 32'(pc_oe), 32'h00);
      bus_rd(8'h03, 8'h15, "R6 pc read pins");

      // R7/R8 handshake for A only
      pc_in = 6'h04;
      bus_wr(8'h00, 8'h04);
      #1;
      chk("R7 pc_oe handshake A", 32'(pc_oe), 32'h3B);
      chk("R8 pc_out input init", 32'(pc_out), 32'h28);
      bus_rd(8'h03, 8'h2C, "R6 pc read mixed");
      bus_wr(8'h00, 8'h05);
      #1;
      chk("R8 pc_out output init intr", 32'(pc_out), 32'h29);
      bus_rd(8'h00, 8'h01, "R8 status output init");

      // R9 strobed input, interrupt disabled
      bus_wr(8'h00, 8'h04);
      pa_in = 8'h3C;
      @(negedge clk); pc_in = 6'h00;
      idle(1);
      @(negedge clk); pc_in = 6'h04;
      idle(1);
      bus_rd(8'h00, 8'h02, "R9 bf set, no intr without enable");
      bus_rd(8'h01, 8'h3C, "R9 captured byte ie off");
      bus_rd(8'h00, 8'h00, "R9 flags cleared ie off");

      // R9 strobed input, interrupt enabled
      bus_wr(8'h00, 8'h14);
      pa_in = 8'h9E;
      @(negedge clk); pc_in = 6'h00;
      @(negedge clk); pa_in = 8'h11;
      #1;
      chk("R9 bf pin after fall", 32'(pc_out[1]), 32'h1);
      chk("R9 intr pin before release", 32'(pc_out[0]), 32'h0);
      @(negedge clk); pc_in = 6'h04;
      @(negedge clk);
      #1;
      chk("R9 intr pin after release", 32'(pc_out[0]), 32'h1);
      bus_rd(8'h00, 8'h07, "R9 status after strobe");
      bus_rd(8'h01, 8'h9E, "R9 latched byte not live pins");
      bus_rd(8'h00, 8'h04, "R9 read clears flags");

      // R11 input: strobe release coincides with read
      @(negedge clk); pc_in = 6'h00;
      idle(1);
      bus_rd(8'h01, 8'h11, "R11 read during release", 6'h04);
      bus_rd(8'h00, 8'h05, "R11 strobe beats read clear");
      bus_rd(8'h01, 8'h11, "R11 clearing read");
      bus_rd(8'h00, 8'h04, "R11 cleared");

      // R10 strobed output
      bus_wr(8'h00, 8'h15);
      bus_rd(8'h00, 8'h05, "R10 output init");
      bus_wr(8'h01, 8'h6D);
      #1;
      chk("R10 pa_out", 32'(pa_out), 32'h6D);
      bus_rd(8'h00, 8'h06, "R10 write sets bf clears intr");
      @(negedge clk); pc_in = 6'h00;
      idle(1);
      bus_rd(8'h00, 8'h06, "R10 fall changes nothing");
      @(negedge clk); pc_in = 6'h04;
      idle(1);
      bus_rd(8'h00, 8'h05, "R10 release clears bf sets intr");
      @(negedge clk); pc_in = 6'h00;
      idle(1);
      bus_wr(8'h01, 8'h12, 6'h04);
      bus_rd(8'h00, 8'h06, "R11 write beats release");
      chk("R11 pa_out after coincidence", 32'(pa_out), 32'h12);

      // R7/R9 port B handshake
      pc_in = 6'h24;
      bus_wr(8'h00, 8'h28);
      #1;
      chk("R7 pc_oe handshake both", 32'(pc_oe), 32'h1B);
      chk("R8 pc_out both inputs", 32'(pc_out), 32'h00);
      pb_in = 8'hE7;
      @(negedge clk); pc_in = 6'h04;
      @(negedge clk); pb_in = 8'h00; pc_in = 6'h24;
      @(negedge clk);
      #1;
      chk("R7 port B flag pins", 32'(pc_out), 32'h18);
      bus_rd(8'h00, 8'h38, "R9 status port B");
      bus_rd(8'h02, 8'hE7, "R9 port B captured byte");
      bus_rd(8'h00, 8'h20, "R9 port B cleared");

      // R12 timer holding registers and unused addresses
      bus_wr(8'h04, 8'h34);
      bus_wr(8'h05, 8'hC7);
      bus_wr(8'h06, 8'hFF);
      bus_rd(8'h04, 8'h34, "R12 timer low");
      bus_rd(8'h05, 8'hC7, "R12 timer high");
      bus_rd(8'h06, 8'h00, "R12 address 6");
      bus_rd(8'h07, 8'h00, "R12 address 7");

      // R3 timer flag in status
      tc_flag = 1'b1;
      bus_rd(8'h00, 8'h60, "R3 status timer flag");
      tc_flag = 1'b0;

      idle(2);
      chk("scoreboard drained", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule